// File: doc/BRIEF.md
# Serial Start-of-Frame Detector with Destination Address Filter

This block sits beside a receive path. It takes the NRZ bit stream that a line decoder produces, one bit on each rising edge of the recovered receive clock. That clock runs only while the line is busy, so the block keeps all of its state through any stretch without edges. While a receive-active qualifier is high, the block hunts for an alternating preamble and for the pair of ones that closes the start-frame delimiter (10101011). When it finds them, it raises a start-of-frame flag.

The 48 bits that follow the delimiter are shifted into a destination-address register. These bits are checked against a small table of stored addresses, and this happens alongside normal frame reception. A single-bit-period strobe reports the decision, and the accept output says whether any enabled table entry matched. The table is loaded from a separate, free-running configuration clock. Software is expected to change the table only between frames.

Top module: `sfd_addr_filter`

## Requirements
- R1: While reset is high at a clock edge, the registers of that domain clear. `sof`, `match_vld` and `accept` read 0, and every table entry becomes disabled.
- R2: `sof` rises after the rx_clk edge that samples the second of two consecutive ones, provided the first of them ended a run of at least MIN_ALT (default 6) strictly alternating bits. Before that edge `sof` is 0.
- R3: A repeated bit is a restart in every case except a closing pair of ones. A pair of ones that follows fewer than MIN_ALT alternating bits is also a restart. After a restart the run count begins again at the current bit and `sof` stays 0.
- R4: Once raised, `sof` stays high while `rx_active` is high. It falls as soon as `rx_active` falls, with no clock edge needed. Any rx_clk edge that samples `rx_active` low returns the hunt and the capture to their idle state.
- R5: The destination address is the 48 bits that follow the delimiter. The k-th received address bit (k = 0..47, counted from the first) goes into bit k of the compared value, so each byte arrives least significant bit first.
- R6: `match_vld` is high for exactly one rx_clk period, starting after the edge that samples the 48th address bit. `accept` is updated on that same edge and keeps its value until the next strobe.
- R7: `accept` is set to 1 only when some table entry has its valid flag set and stores exactly the captured address. A write on `cfg_clk` with `tab_we` high replaces entry `tab_idx` with `tab_mac` and `tab_valid`.
- R8: If `rx_active` is sampled low before the 48th address bit, no strobe occurs. This includes the edge that would have carried the 48th bit. `accept` is left unchanged.
- R9: After the strobe, further bits in the same frame produce no strobe and leave `accept` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive bit clock; may stop between frames |
| cfg_clk | input | 1 | Free-running clock for table writes |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| rx_data | input | 1 | Decoded NRZ receive bit, sampled on rising rx_clk |
| rx_active | input | 1 | Receive-activity qualifier |
| tab_we | input | 1 | Table write enable (cfg_clk) |
| tab_idx | input | IDX_W (2) | Table entry to write |
| tab_mac | input | 48 | Address to store |
| tab_valid | input | 1 | Enable flag to store with the address |
| sof | output | 1 | Start-of-frame flag |
| match_vld | output | 1 | One-bit-period strobe: address decision ready |
| accept | output | 1 | Decision: captured address matches an enabled entry |

## Verification
Two events can land on the same rx_clk edge: the 48th address bit completing the capture, and the end of the frame as seen through `rx_active`. The bench provokes this by dropping `rx_active` on exactly the edge that would carry the 48th bit. It judges the outcome by checking that the scoreboard receives no strobe and that `accept` keeps its earlier value. A second collision is the closing pair of ones arriving right after a broken alternation. That case is judged by `sof` staying low on the edge after the pair.

// File: rtl/sfdf_pkg.sv
package sfdf_pkg;

    localparam int MAC_W = 48;

    typedef logic [MAC_W-1:0] mac_t;

    typedef struct packed {
        logic vld;
        mac_t mac;
    } tab_ent_t;

    typedef enum logic [1:0] {
        CAP_IDLE = 2'd0,
        CAP_RUN  = 2'd1,
        CAP_DONE = 2'd2
    } cap_st_t;

    function automatic logic ent_hit(input tab_ent_t e, input mac_t a);
        return e.vld && (e.mac == a);
    endfunction

endpackage

// File: rtl/sfdf_hunt.sv
// Delimiter hunt: counts a run of alternating bits and flags the closing 11.
module sfdf_hunt #(
    parameter int MIN_ALT = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic bit_in,
    output logic found
);
    localparam int CW = $clog2(MIN_ALT + 1);
    localparam logic [CW-1:0] RUN_MIN = CW'(MIN_ALT);

    logic [CW-1:0] run;
    logic          prev;

    always_ff @(posedge clk) begin
        if (rst || !act) begin
            run   <= '0;
            prev  <= 1'b0;
            found <= 1'b0;
        end else if (!found) begin
            if (bit_in != prev) begin
                if (run < RUN_MIN) run <= run + 1'b1;
            end else if (bit_in && run >= RUN_MIN) begin
                found <= 1'b1;
            end else begin
                run <= CW'(1);
            end
            prev <= bit_in;
        end
    end
endmodule

// File: rtl/sfdf_capture.sv
// Address shift register, bit counter and decision register.
module sfdf_capture
    import sfdf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic act,
    input  logic go,
    input  logic bit_in,
    input  logic hit,
    output mac_t cand,
    output logic strobe,
    output logic accept
);
    localparam int CNT_W = $clog2(MAC_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MAC_W - 1);

    cap_st_t          st;
    logic [CNT_W-1:0] cnt;
    logic [MAC_W-2:0] sh;

    // Current bit joins the 47 already held; first received bit ends at bit 0.
    assign cand = {bit_in, sh};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= CAP_IDLE;
            cnt    <= '0;
            sh     <= '0;
            strobe <= 1'b0;
            accept <= 1'b0;
        end else begin
            strobe <= 1'b0;
            if (!act) begin
                st  <= CAP_IDLE;
                cnt <= '0;
            end else if (go && st != CAP_DONE) begin
                sh <= cand[MAC_W-1:1];
                if (cnt == LAST) begin
                    st     <= CAP_DONE;
                    strobe <= 1'b1;
                    accept <= hit;
                end else begin
                    st  <= CAP_RUN;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sfdf_table.sv
// Address table, written on cfg_clk; parallel compare against the candidate.
module sfdf_table
    import sfdf_pkg::*;
#(
    parameter int NUM_ENT = 4,
    parameter int IDX_W   = 2
) (
    input  logic             cfg_clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  mac_t             wmac,
    input  logic             wvld,
    input  mac_t             cand,
    output logic             hit
);
    logic [NUM_ENT-1:0] hits;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        tab_ent_t e;
        always_ff @(posedge cfg_clk) begin
            if (rst) begin
                e <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                e <= '{vld: wvld, mac: wmac};
            end
        end
        assign hits[g] = ent_hit(e, cand);
    end

    assign hit = |hits;
endmodule

// File: rtl/sfd_addr_filter.sv
module sfd_addr_filter
    import sfdf_pkg::*;
#(
    parameter  int NUM_ENT = 4,
    parameter  int MIN_ALT = 6,
    localparam int IDX_W   = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
    input  logic             rx_clk,
    input  logic             cfg_clk,
    input  logic             rst,
    input  logic             rx_data,
    input  logic             rx_active,
    input  logic             tab_we,
    input  logic [IDX_W-1:0] tab_idx,
    input  logic [MAC_W-1:0] tab_mac,
    input  logic             tab_valid,
    output logic             sof,
    output logic             match_vld,
    output logic             accept
);
    logic found;
    logic hit;
    mac_t cand;

    sfdf_hunt #(.MIN_ALT(MIN_ALT)) u_hunt (
        .clk    (rx_clk),
        .rst    (rst),
        .act    (rx_active),
        .bit_in (rx_data),
        .found  (found)
    );

    sfdf_capture u_cap (
        .clk    (rx_clk),
        .rst    (rst),
        .act    (rx_active),
        .go     (found),
        .bit_in (rx_data),
        .hit    (hit),
        .cand   (cand),
        .strobe (match_vld),
        .accept (accept)
    );

    sfdf_table #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_tab (
        .cfg_clk (cfg_clk),
        .rst     (rst),
        .we      (tab_we),
        .idx     (tab_idx),
        .wmac    (tab_mac),
        .wvld    (tab_valid),
        .cand    (cand),
        .hit     (hit)
    );

    // Flag falls with the qualifier even if the bit clock has already stopped.
    assign sof = found & rx_active;
endmodule

// File: rtl/sfd_addr_filter_chk.sv
module sfd_addr_filter_chk (
    input logic rx_clk,
    input logic rst,
    input logic rx_data,
    input logic rx_active,
    input logic found,
    input logic sof,
    input logic match_vld
);
    assert_sof_on_double_one_R2: assert property (@(posedge rx_clk) disable iff (rst)
        $rose(found) |-> ($past(rx_data) && $past(rx_data, 2) && $past(rx_active)));

    assert_sof_follows_qualifier_R4: assert property (@(posedge rx_clk) disable iff (rst)
        !rx_active |-> !sof);

    assert_idle_clears_hunt_R4: assert property (@(posedge rx_clk) disable iff (rst)
        !rx_active |=> !found);

    assert_strobe_after_delimiter_R5: assert property (@(posedge rx_clk) disable iff (rst)
        match_vld |-> found);

    assert_strobe_one_period_R6: assert property (@(posedge rx_clk) disable iff (rst)
        match_vld |=> !match_vld);

    assert_no_strobe_on_idle_R8: assert property (@(posedge rx_clk) disable iff (rst)
        !rx_active |=> !match_vld);
endmodule

bind sfd_addr_filter sfd_addr_filter_chk u_chk (
    .rx_clk    (rx_clk),
    .rst       (rst),
    .rx_data   (rx_data),
    .rx_active (rx_active),
    .found     (found),
    .sof       (sof),
    .match_vld (match_vld)
);

// File: tb/sfd_addr_filter_bench.sv
module sfd_addr_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CFG_PERIOD = 8;

    logic        rx_clk = 0, cfg_clk = 0, rst = 1;
    logic        rx_data = 0, rx_active = 0;
    logic        tab_we = 0, tab_valid = 0;
    logic [1:0]  tab_idx = 0;
    logic [47:0] tab_mac = 0;
    logic        sof, match_vld, accept;

    int  n_chk = 0, n_fail = 0;
    bit  exp_q[$];
    bit  finished = 0;

    sfd_addr_filter u_sfd_addr_filter (
        .rx_clk(rx_clk), .cfg_clk(cfg_clk), .rst(rst),
        .rx_data(rx_data), .rx_active(rx_active),
        .tab_we(tab_we), .tab_idx(tab_idx), .tab_mac(tab_mac), .tab_valid(tab_valid),
        .sof(sof), .match_vld(match_vld), .accept(accept)
    );

    always #(CFG_PERIOD/2) cfg_clk = ~cfg_clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic a);
        rx_data = b; rx_active = a;
        #(CLK_PERIOD/2) rx_clk = 1;
        #(CLK_PERIOD/2) rx_clk = 0;
    endtask

    task automatic write_entry(input int idx, input logic [47:0] mac, input logic v);
        @(negedge cfg_clk);
        tab_we = 1; tab_idx = 2'(idx); tab_mac = mac; tab_valid = v;
        @(negedge cfg_clk);
        tab_we = 0;
    endtask

    // Scoreboard monitor: each strobe pops one expected decision.
    initial begin
        forever begin
            @(posedge rx_clk);
            #1;
            if (!rst && match_vld) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6/R8 unexpected strobe", 1, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    check(accept == e, "R7 decision", accept, e);
                end
            end
        end
    end

    task automatic run_frame(input int npre, input logic [47:0] mac, input bit rev,
                             input int naddr, input bit exp_sof, input bit exp_acc);
        logic acc_before;
        for (int i = 0; i < npre; i++) send_bit(((npre - 1 - i) % 2) == 0, 1);
        check(sof == 0, "R2 sof low before closing one", sof, 0);
        send_bit(1, 1);
        check(sof == exp_sof, "R2/R3 sof after closing pair", sof, exp_sof);
        acc_before = accept;
        if (exp_sof) begin
            for (int k = 0; k < naddr; k++) begin
                if (k == 47) exp_q.push_back(exp_acc);
                send_bit(rev ? mac[47-k] : mac[k], 1);
            end
            if (naddr == 48) begin
                check(match_vld == 1, "R6 strobe after 48th bit", match_vld, 1);
                send_bit(1, 1);
                check(match_vld == 0, "R6 strobe one period", match_vld, 0);
                send_bit(0, 1);
                send_bit(1, 1);
                check(accept == exp_acc, "R9 accept held after strobe", accept, exp_acc);
                check(sof == 1, "R4 sof held while active", sof, 1);
            end else begin
                check(match_vld == 0, "R8 no strobe mid-address", match_vld, 0);
            end
        end
        rx_active = 0; rx_data = 0;
        #1;
        check(sof == 0, "R4 sof drops with qualifier", sof, 0);
        send_bit(0, 0);
        if (naddr < 48)
            check(accept == acc_before, "R8 accept unchanged on short frame", accept, acc_before);
        send_bit(0, 0);
        check(match_vld == 0, "R8 idle no strobe", match_vld, 0);
    endtask

    localparam logic [47:0] MAC_A = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] MAC_B = 48'hF0E1_D2C3_B4A5;
    localparam logic [47:0] MAC_C = 48'h1357_9BDF_0246;
    localparam logic [47:0] MAC_D = 48'h8000_0000_0001;
    localparam logic [47:0] MAC_E = 48'h0A1B_2C3D_4E5E;

    initial begin
        for (int i = 0; i < 4; i++) send_bit(0, 0);
        @(negedge cfg_clk); @(negedge cfg_clk);
        rst = 0;
        #1;
        check(sof == 0, "R1 reset sof", sof, 0);
        check(match_vld == 0, "R1 reset strobe", match_vld, 0);
        check(accept == 0, "R1 reset accept", accept, 0);

        // Table cleared by reset: a frame with all-zero address must be rejected (R1).
        run_frame(6, 48'h0, 0, 48, 1, 0);

        write_entry(0, MAC_A, 1);
        write_entry(1, MAC_B, 1);
        write_entry(2, MAC_C, 0);
        write_entry(3, MAC_D, 1);

        run_frame(8, MAC_A, 0, 48, 1, 1);   // R5 R7 match entry 0
        run_frame(6, MAC_E, 0, 48, 1, 0);   // R7 one-bit difference rejected
        run_frame(7, MAC_C, 0, 48, 1, 0);   // R7 disabled entry rejected
        run_frame(9, MAC_A, 1, 48, 1, 0);   // R5 reversed bit order rejected
        run_frame(10, MAC_D, 0, 48, 1, 1);  // R7 last entry
        run_frame(5, MAC_A, 0, 48, 0, 0);   // R3 short run: no sof

        // R3: alternation broken by 00, then only 4 alternating bits before 11.
        begin
            bit pat[11] = '{1,0,1,0,1,0,0,1,0,1,1};
            foreach (pat[i]) send_bit(pat[i], 1);
            check(sof == 0, "R3 broken alternation restarts", sof, 0);
            send_bit(0, 0);
        end

        run_frame(6, MAC_B, 0, 20, 1, 0);   // R8 early end
        run_frame(6, MAC_B, 0, 47, 1, 0);   // R8 end on the 48th-bit edge

        write_entry(1, MAC_C, 1);
        run_frame(6, MAC_C, 0, 48, 1, 1);   // R7 rewritten entry matches
        run_frame(6, MAC_B, 0, 48, 1, 0);   // R7 old contents gone

        check(exp_q.size() == 0, "R6 all expected strobes seen", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule